// File: doc/BRIEF.md
# Simultaneous-Sampling ADC Conversion and Readout Controller

This block sits on the host side of an external converter that samples two channel groups at once. A start request in idle raises the conversion-start output. The block then waits for the converter's busy input to rise and fall again. After that it runs one serial read frame, using an active-low chip-select, a serial clock it divides down from the system clock, and one or two data inputs. When the frame ends, the A result, the B result and an optional status word are written into output registers, and a one-cycle done flag is raised.

Three configuration inputs are sampled when the request is accepted:

- Lane count: dual-lane or single-lane.
- Status word: whether one is appended after the results.
- Single-lane framing: one chip-select frame or two 16-clock frames.

The serial clock rate and the busy timeout are also inputs. If busy never arrives, or never clears, the controller ends the run with an error flag and does not read.

Top module: `adc_rd_ctrl`

## Requirements
- R1: A start pulse in idle drives `conv_st` from low to high. `conv_st` stays high until `busy` is seen high, then returns low. A start pulse while a run is in progress is ignored, so no second rising edge of `conv_st` occurs.
- R2: `cs_n` stays high from the start request until `busy` has been seen low after its rise. No frame is open while `busy` is high.
- R3: Each half period of `sclk` lasts `clk_div`+1 system clocks, so one full period is 2·(`clk_div`+1). `sclk` is low whenever `cs_n` is high, and each frame starts with `sclk` low.
- R4: Words are 16 bits, MSB first. The bit present on a data input just before a rising edge of `sclk` is the one captured. The first bit is valid from the falling edge of `cs_n`.
- R5: Dual-lane mode (`dual`=1) uses 16 `sclk` cycles. `res_a` is read from `sdo_a` and `res_b` from `sdo_b`, in the same 16 clocks.
- R6: Single-lane mode (`dual`=0) uses 32 `sclk` cycles on `sdo_a` and ignores `sdo_b`. The first 16 bits go to `res_a` and the next 16 to `res_b`.
- R7: In single-lane mode without status, `split`=1 closes the frame after 16 clocks. `cs_n` then stays high for one half period and a second 16-clock frame follows, giving two `cs_n` falling edges. `split`=0 gives one frame. In dual-lane mode `split` has no effect.
- R8: With `stat_en`=1, a further 16 clocks follow on `sdo_a` after the result words, and that word goes to `res_stat`. `cs_n` stays low for the whole frame even when `split`=1. With `stat_en`=0, `res_stat` is written as 0.
- R9: The run ends in error in two cases: `busy` does not rise within `busy_to` clocks of `conv_st` rising, or it does not fall within `busy_to` clocks of its rise. In either case `done` and `err` pulse together, no `cs_n` frame is opened, and `res_a`, `res_b` and `res_stat` keep their previous values.
- R10: On a successful run, `done` is high for exactly one cycle with `err` low. The new results are visible in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Run request, taken only in idle |
| dual | input | 1 | 1: two data lanes, 0: one lane |
| stat_en | input | 1 | Append status word to the frame |
| split | input | 1 | Single lane: two 16-clock frames |
| clk_div | input | DIV_W | Serial clock half period minus one, in system clocks |
| busy_to | input | TO_W | Busy wait limit in system clocks |
| busy | input | 1 | Converter busy |
| sdo_a | input | 1 | First serial data input |
| sdo_b | input | 1 | Second serial data input |
| conv_st | output | 1 | Conversion-start strobe |
| cs_n | output | 1 | Active-low chip-select |
| sclk | output | 1 | Serial clock |
| res_a | output | DW | A-channel result |
| res_b | output | DW | B-channel result |
| res_stat | output | DW | Status word, 0 when not requested |
| done | output | 1 | One-cycle completion flag |
| err | output | 1 | Busy timeout, pulses with done |

## Verification
The bench models the converter. It presents the MSB when `cs_n` falls and advances on each rising edge of `sclk`, across frame boundaries. A controller that sampled one edge late would return every result shifted left by one bit. A controller that reset its capture between split frames would return a wrong B word. The bench counts chip-select frames and serial clocks in each mode, so a controller that split a frame with status appended, or ran the wrong number of clocks, shows up as a count mismatch. Runs where `busy` never rises and where it never falls check that no frame opens and the previous results survive. A start request issued mid-run checks that `conv_st` does not rise a second time.

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl #(
  parameter int DW    = 16,
  parameter int DIV_W = 8,
  parameter int TO_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dual,
  input  logic             stat_en,
  input  logic             split,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [TO_W-1:0]  busy_to,
  input  logic             busy,
  input  logic             sdo_a,
  input  logic             sdo_b,
  output logic             conv_st,
  output logic             cs_n,
  output logic             sclk,
  output logic [DW-1:0]    res_a,
  output logic [DW-1:0]    res_b,
  output logic [DW-1:0]    res_stat,
  output logic             done,
  output logic             err
);
  localparam int MAXW = 3;
  localparam int SH_W = DW * MAXW;
  localparam int BC_W = $clog2(SH_W + 1);

  typedef enum logic [2:0] {IDLE, WHI, WLO, LEAD, SHIFT, GAP, FIN} st_t;
  st_t st;

  logic             cfg_dual, cfg_stat, cfg_split;
  logic [DIV_W-1:0] div_q;
  logic [TO_W-1:0]  to_cnt;
  logic [DIV_W-1:0] dcnt;
  logic [BC_W-1:0]  bitcnt;
  logic [SH_W-1:0]  sh_a;
  logic [DW-1:0]    sh_b;

  logic [1:0]      words;
  logic [BC_W-1:0] total_bits;
  logic            tick, split_act, in_frame;
  int              idx_a, idx_b;

  assign words      = (cfg_dual ? 2'd1 : 2'd2) + {1'b0, cfg_stat};
  assign total_bits = BC_W'(words) * BC_W'(DW);
  assign tick       = (dcnt == div_q);
  assign split_act  = cfg_split && !cfg_dual && !cfg_stat;
  assign in_frame   = (st == LEAD) || (st == SHIFT) || (st == GAP);
  assign idx_a      = (int'(words) - 1) * DW;
  assign idx_b      = cfg_dual ? 0 : (int'(words) - 2) * DW;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dcnt <= '0;
    else if (!in_frame || tick) dcnt <= '0;
    else dcnt <= dcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;
      cfg_dual <= 1'b0; cfg_stat <= 1'b0; cfg_split <= 1'b0;
      div_q <= '0; to_cnt <= '0; bitcnt <= '0;
      sh_a <= '0; sh_b <= '0;
      conv_st <= 1'b0; cs_n <= 1'b1; sclk <= 1'b0;
      res_a <= '0; res_b <= '0; res_stat <= '0;
      done <= 1'b0; err <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        IDLE: if (start) begin
          cfg_dual <= dual; cfg_stat <= stat_en; cfg_split <= split;
          div_q <= clk_div;
          to_cnt <= '0;
          conv_st <= 1'b1;
          st <= WHI;
        end
        WHI: begin
          if (busy) begin
            conv_st <= 1'b0;
            to_cnt <= '0;
            st <= WLO;
          end else if (to_cnt == busy_to) begin
            conv_st <= 1'b0;
            done <= 1'b1; err <= 1'b1;
            st <= IDLE;
          end else to_cnt <= to_cnt + 1'b1;
        end
        WLO: begin
          if (!busy) begin
            cs_n <= 1'b0;
            bitcnt <= '0;
            st <= LEAD;
          end else if (to_cnt == busy_to) begin
            done <= 1'b1; err <= 1'b1;
            st <= IDLE;
          end else to_cnt <= to_cnt + 1'b1;
        end
        LEAD: if (tick) st <= SHIFT;
        SHIFT: if (tick) begin
          if (!sclk) begin
            sclk <= 1'b1;
            sh_a <= {sh_a[SH_W-2:0], sdo_a};
            if (bitcnt < BC_W'(DW)) sh_b <= {sh_b[DW-2:0], sdo_b};
            bitcnt <= bitcnt + 1'b1;
          end else begin
            sclk <= 1'b0;
            if (bitcnt == total_bits) begin
              cs_n <= 1'b1;
              st <= FIN;
            end else if (split_act && bitcnt == BC_W'(DW)) begin
              cs_n <= 1'b1;
              st <= GAP;
            end
          end
        end
        GAP: if (tick) begin
          cs_n <= 1'b0;
          st <= LEAD;
        end
        FIN: begin
          res_a    <= sh_a[idx_a +: DW];
          res_b    <= cfg_dual ? sh_b : sh_a[idx_b +: DW];
          res_stat <= cfg_stat ? sh_a[DW-1:0] : '0;
          done <= 1'b1;
          st <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end

  AST_CONV_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_st) |-> $past(st == IDLE)); // R1
  AST_NO_CS_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == WHI || st == WLO) |-> cs_n); // R2
  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk); // R3
  AST_STAT_ONE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cs_n) && cfg_stat) |-> (bitcnt == total_bits)); // R8
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
endmodule

// File: tb/adc_rd_ctrl_bench.sv
module adc_rd_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, dual = 1'b0, stat_en = 1'b0, split = 1'b0;
  logic [7:0] clk_div = 8'd0;
  logic [15:0] busy_to = 16'd200;
  logic busy = 1'b0, sdo_a = 1'b0, sdo_b = 1'b0;
  logic conv_st, cs_n, sclk, done, err;
  logic [15:0] res_a, res_b, res_stat;

  always #2.5 clk = ~clk;

  adc_rd_ctrl u_adc_rd_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .dual(dual), .stat_en(stat_en),
    .split(split), .clk_div(clk_div), .busy_to(busy_to), .busy(busy),
    .sdo_a(sdo_a), .sdo_b(sdo_b), .conv_st(conv_st), .cs_n(cs_n), .sclk(sclk),
    .res_a(res_a), .res_b(res_b), .res_stat(res_stat), .done(done), .err(err));

  int checks = 0, fails = 0;
  int frames = 0, rises = 0, conv_rises = 0, busy_viol = 0, cyc = 0, ptr = 0;
  int rc0 = 0, rc1 = 0;
  int bmode = 1, bdly = 3, blen = 12;
  logic [47:0] str_a = '0, str_b = '0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge conv_st) begin
    conv_rises = conv_rises + 1;
    ptr = 0;
    if (bmode != 0) begin
      repeat (bdly) @(posedge clk);
      busy <= 1'b1;
      if (bmode == 1) begin
        repeat (blen) @(posedge clk);
        busy <= 1'b0;
      end
    end
  end

  always @(negedge cs_n) begin
    frames = frames + 1;
    sdo_a = (ptr < 48) ? str_a[47-ptr] : 1'b0;
    sdo_b = (ptr < 48) ? str_b[47-ptr] : 1'b0;
  end

  always @(posedge sclk) begin
    if (rises == 0) rc0 = cyc;
    if (rises == 1) rc1 = cyc;
    rises = rises + 1;
    ptr = ptr + 1;
    sdo_a <= (ptr < 48) ? str_a[47-ptr] : 1'b0;
    sdo_b <= (ptr < 48) ? str_b[47-ptr] : 1'b0;
  end

  always @(negedge clk) if (busy && !cs_n) busy_viol = busy_viol + 1;

  task automatic chk(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(output logic got);
    got = 1'b0;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (done) begin got = 1'b1; break; end
    end
  endtask

  // {dual, stat, split, div[4:0], A, B, S, frames}
  localparam logic [63:0] VEC [6] = '{
    {1'b1, 1'b0, 1'b0, 5'd0, 16'h1234, 16'hABCD, 16'h0000, 8'd1},
    {1'b1, 1'b1, 1'b0, 5'd1, 16'h8001, 16'h7FFE, 16'h5A5A, 8'd1},
    {1'b0, 1'b0, 1'b0, 5'd0, 16'hFFFF, 16'h0000, 16'h1111, 8'd1},
    {1'b0, 1'b0, 1'b1, 5'd2, 16'h0F0F, 16'hF0F0, 16'h2222, 8'd2},
    {1'b0, 1'b1, 1'b1, 5'd0, 16'hDEAD, 16'hBEEF, 16'hC3C3, 8'd1},
    {1'b1, 1'b1, 1'b1, 5'd3, 16'h0001, 16'h8000, 16'hFFFF, 8'd1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    logic got;
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1 && sclk === 1'b0 && conv_st === 1'b0, "R3 reset idle pins", {cs_n, sclk, conv_st}, 3'b100);
    chk(done === 1'b0 && err === 1'b0 && res_a === 16'h0, "R10 reset outputs", {done, err, res_a}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 6; v++) begin
      logic [15:0] ea, eb, es;
      int words;
      dual = VEC[v][63]; stat_en = VEC[v][62]; split = VEC[v][61];
      clk_div = {3'b0, VEC[v][60:56]};
      ea = VEC[v][55:40]; eb = VEC[v][39:24]; es = VEC[v][23:8];
      words = (dual ? 1 : 2) + (stat_en ? 1 : 0);
      str_a = dual ? {ea, es, 16'h0} : {ea, eb, es};
      str_b = {eb, 32'h0};
      frames = 0; rises = 0; busy_viol = 0;
      bmode = 1;
      pulse_start();
      wait_done(got);
      chk(got, "R10 done seen", got, 1);
      chk(res_a === ea, dual ? "R5 dual res_a" : "R6 single res_a R4", res_a, ea);
      chk(res_b === eb, dual ? "R5 dual res_b" : "R6 single res_b R4", res_b, eb);
      chk(res_stat === (stat_en ? es : 16'h0), "R8 res_stat", res_stat, stat_en ? es : 16'h0);
      chk(err === 1'b0, "R10 no err", err, 0);
      chk(frames == int'(VEC[v][7:0]), "R7 frame count", frames, VEC[v][7:0]);
      chk(rises == 16 * words, "R5 R6 R8 sclk count", rises, 16 * words);
      chk(busy_viol == 0, "R2 no frame while busy", busy_viol, 0);
      @(negedge clk);
      chk(done === 1'b0, "R10 done single cycle", done, 0);
    end

    // R3 divider period
    dual = 1'b1; stat_en = 1'b0; split = 1'b0; clk_div = 8'd4;
    str_a = {16'h4321, 32'h0}; str_b = {16'h9876, 32'h0};
    rises = 0;
    pulse_start();
    wait_done(got);
    chk(rc1 - rc0 == 10, "R3 sclk period", rc1 - rc0, 10);
    chk(res_a === 16'h4321 && res_b === 16'h9876, "R4 MSB first at div 4", res_a, 16'h4321);

    // R1 conv_st held until busy, then dropped; restart ignored
    clk_div = 8'd0; bdly = 6; conv_rises = 0;
    pulse_start();
    @(negedge clk);
    chk(conv_st === 1'b1 && busy === 1'b0, "R1 conv_st high before busy", conv_st, 1);
    repeat (8) @(negedge clk);
    chk(conv_st === 1'b0 && busy === 1'b1, "R1 conv_st low after busy", conv_st, 0);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done(got);
    repeat (5) @(negedge clk);
    chk(conv_rises == 1, "R1 start ignored while running", conv_rises, 1);
    bdly = 3;

    // R9 busy never rises
    busy_to = 16'd20; bmode = 0; frames = 0;
    pulse_start();
    wait_done(got);
    chk(got && err === 1'b1, "R9 timeout no rise", err, 1);
    chk(frames == 0 && res_a === 16'h4321, "R9 no frame, results kept", res_a, 16'h4321);

    // R9 busy never falls
    bmode = 2; frames = 0;
    pulse_start();
    wait_done(got);
    chk(got && err === 1'b1, "R9 timeout no fall", err, 1);
    chk(frames == 0 && res_b === 16'h9876, "R9 no frame, res_b kept", res_b, 16'h9876);
    busy = 1'b0;
    repeat (3) @(negedge clk);

    finish_run();
  end
endmodule